// File: doc/BRIEF.md
# Priority-Safe Pad Function Multiplexer

This block places a set of peripheral functions onto a set of chip pads. Each pad holds a small selection code. Code zero leaves the pad under general-purpose I/O control. A code from 1 to the number of functions hands the pad to that function. On the output side, each function's output value is routed to every pad whose code names it. On the input side, each function input is fed by an index-ordered priority multiplexer over all pads that claim it. Because of this, a configuration written by mistake can never tie two pads together onto one function input.

Three kinds of function are set by parameters. Output functions drive their pad with output-enable asserted. Input functions leave the pad undriven. Bidirectional bus functions, such as a two-wire serial data line or a memory-card data line, drive the pad's output-enable themselves. Every pad input passes through a two-stage synchronizer before it reaches a function or the GPIO input bus. A function input that no pad claims rests at a per-function idle level.

Configuration uses a simple write port. Addresses 0 to NUM_PINS-1 hold the per-pad selection codes in the low bits of the data word. Address NUM_PINS holds the GPIO output values. Address NUM_PINS+1 holds the GPIO output-enables. All other addresses are ignored.

Top module: `pinmux_core`

## Requirements
- R1: After reset every selection code is 0 and both GPIO registers are 0. So pad_oe is all zero, pad_out is all zero, and each fn_in sits at its idle level (function bit set in IDLE_MASK gives 1, otherwise 0).
- R2: A pad whose code is 0 drives pad_out from its bit of the GPIO output register and pad_oe from its bit of the GPIO enable register.
- R3: A pad whose code is c (1 to NUM_FUNCS) names function index c-1. Its pad_out equals fn_out[c-1]. If that function is an output type (OUT_MASK bit set), pad_oe is 1. If it is an input type, pad_oe is 0. Several pads may name the same output function, and each of them carries its value.
- R4: A pad whose code names a bus function (BUS_MASK bit set) takes its pad_oe from fn_oe of that function, cycle by cycle.
- R5: When several pads name the same function, fn_in of that function equals the synchronized input of the lowest-indexed such pad.
- R6: A function that no pad names holds fn_in at its idle level whatever the pads carry.
- R7: gpio_in carries the synchronized input of every pad, whatever the pad's mode.
- R8: A change on pad_in reaches gpio_in and a claiming fn_in exactly two clock edges later, and not after one.
- R9: A code above NUM_FUNCS makes the pad behave as in GPIO mode, and the pad claims no function input.
- R10: A write changes its register on the clock edge that samples cfg_we, and not before. A write to an address at or above NUM_PINS+2 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | AW (4) | Register address |
| cfg_wdata | input | DW (8) | Write data |
| fn_out | input | NUM_FUNCS (6) | Output value of each function |
| fn_oe | input | NUM_FUNCS (6) | Direction request of each function (used by bus functions) |
| fn_in | output | NUM_FUNCS (6) | Input delivered to each function |
| pad_in | input | NUM_PINS (8) | Raw value seen at each pad |
| pad_out | output | NUM_PINS (8) | Value driven to each pad |
| pad_oe | output | NUM_PINS (8) | Output-enable for each pad |
| gpio_in | output | NUM_PINS (8) | Synchronized pad values for GPIO reads |

## Verification
The assertions check several rules on every cycle: GPIO-mode pads follow their registers, bus-function pads follow the function's direction request, at most one pad wins each function input, unclaimed inputs rest at idle, out-of-range codes claim nothing, the synchronizer delay is exactly two edges, and each write lands in its register one edge later. Some behaviour can only be shown by the bench's scenarios. These are the reset values, which pad actually wins when several claim a function as claims are added and removed, the input-only direction of receive functions, that a write is not visible before its edge, and that writes to unused addresses leave every output unchanged.

// File: rtl/pmx_pkg.sv
package pmx_pkg;

  // bits needed to hold codes 0..n_funcs
  function automatic int unsigned field_width(int unsigned n_funcs);
    if (n_funcs < 1) return 1;
    return $clog2(n_funcs + 1);
  endfunction

  function automatic int unsigned wider(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // true when a code hands the pad to one of the functions
  function automatic bit code_selects(int unsigned code, int unsigned n_funcs);
    return (code >= 1) && (code <= n_funcs);
  endfunction

endpackage

// File: rtl/pmx_cfg_regs.sv
module pmx_cfg_regs #(
  parameter int P     = 8,
  parameter int SEL_W = 3,
  parameter int AW    = 4,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [P*SEL_W-1:0] sel_flat,
  output logic [P-1:0]     gpio_out_q,
  output logic [P-1:0]     gpio_oe_q
);
  localparam int GOUT_ADDR = P;
  localparam int GOE_ADDR  = P + 1;

  logic wr_gout;
  logic wr_goe;

  assign wr_gout = we && (addr == AW'(GOUT_ADDR));
  assign wr_goe  = we && (addr == AW'(GOE_ADDR));

  for (genvar p = 0; p < P; p++) begin : g_sel
    logic hit;
    assign hit = we && (addr == AW'(p));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   sel_flat[p*SEL_W +: SEL_W] <= '0;
      else if (hit) sel_flat[p*SEL_W +: SEL_W] <= wdata[SEL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gpio_out_q <= '0;
      gpio_oe_q  <= '0;
    end else begin
      if (wr_gout) gpio_out_q <= wdata[P-1:0];
      if (wr_goe)  gpio_oe_q  <= wdata[P-1:0];
    end
  end
endmodule

// File: rtl/pmx_sync.sv
module pmx_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      st[s] <= '0;
      else if (s == 0) st[s] <= d;
      else             st[s] <= st[(s == 0) ? 0 : s-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/pmx_pin_drive.sv
module pmx_pin_drive #(
  parameter int           F        = 6,
  parameter int           SEL_W    = 3,
  parameter logic [F-1:0] OUT_MASK = '0,
  parameter logic [F-1:0] BUS_MASK = '0
) (
  input  logic [SEL_W-1:0] code,
  input  logic [F-1:0]     fn_out,
  input  logic [F-1:0]     fn_oe,
  input  logic             gpio_out,
  input  logic             gpio_oe,
  output logic             pad_out,
  output logic             pad_oe
);
  always_comb begin
    pad_out = gpio_out;
    pad_oe  = gpio_oe;
    if (pmx_pkg::code_selects(int'(code), F)) begin
      for (int f = 0; f < F; f++) begin
        if (code == SEL_W'(f + 1)) begin
          pad_out = fn_out[f];
          pad_oe  = BUS_MASK[f] ? fn_oe[f] : OUT_MASK[f];
        end
      end
    end
  end
endmodule

// File: rtl/pmx_prio_mux.sv
module pmx_prio_mux #(
  parameter int N = 8
) (
  input  logic [N-1:0] req,
  input  logic [N-1:0] data,
  output logic [N-1:0] grant,
  output logic         any,
  output logic         y
);
  always_comb begin
    grant = '0;
    any   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !any) begin
        grant[i] = 1'b1;
        any      = 1'b1;
      end
    end
  end

  assign y = |(grant & data);
endmodule

// File: rtl/pinmux_core.sv
module pinmux_core #(
  parameter int NUM_PINS  = 8,
  parameter int NUM_FUNCS = 6,
  parameter logic [NUM_FUNCS-1:0] OUT_MASK  = 6'b100101,
  parameter logic [NUM_FUNCS-1:0] BUS_MASK  = 6'b011000,
  parameter logic [NUM_FUNCS-1:0] IDLE_MASK = 6'b001100,
  localparam int SEL_W = pmx_pkg::field_width(NUM_FUNCS),
  localparam int AW    = $clog2(NUM_PINS + 2),
  localparam int DW    = pmx_pkg::wider(NUM_PINS, SEL_W)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [AW-1:0]        cfg_addr,
  input  logic [DW-1:0]        cfg_wdata,
  input  logic [NUM_FUNCS-1:0] fn_out,
  input  logic [NUM_FUNCS-1:0] fn_oe,
  output logic [NUM_FUNCS-1:0] fn_in,
  input  logic [NUM_PINS-1:0]  pad_in,
  output logic [NUM_PINS-1:0]  pad_out,
  output logic [NUM_PINS-1:0]  pad_oe,
  output logic [NUM_PINS-1:0]  gpio_in
);
  localparam int P = NUM_PINS;
  localparam int F = NUM_FUNCS;

  logic [P*SEL_W-1:0] sel_flat;
  logic [P-1:0]       gpio_out_q;
  logic [P-1:0]       gpio_oe_q;
  logic [P-1:0]       pad_sync;
  logic [F*P-1:0]     claim_flat;
  logic [F*P-1:0]     grant_flat;
  logic [F-1:0]       hit;
  logic [F-1:0]       win;

  pmx_cfg_regs #(.P(P), .SEL_W(SEL_W), .AW(AW), .DW(DW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (cfg_we),
    .addr       (cfg_addr),
    .wdata      (cfg_wdata),
    .sel_flat   (sel_flat),
    .gpio_out_q (gpio_out_q),
    .gpio_oe_q  (gpio_oe_q)
  );

  pmx_sync #(.W(P), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (pad_sync)
  );

  assign gpio_in = pad_sync;

  for (genvar p = 0; p < P; p++) begin : g_pin
    pmx_pin_drive #(
      .F(F), .SEL_W(SEL_W), .OUT_MASK(OUT_MASK), .BUS_MASK(BUS_MASK)
    ) u_drv (
      .code     (sel_flat[p*SEL_W +: SEL_W]),
      .fn_out   (fn_out),
      .fn_oe    (fn_oe),
      .gpio_out (gpio_out_q[p]),
      .gpio_oe  (gpio_oe_q[p]),
      .pad_out  (pad_out[p]),
      .pad_oe   (pad_oe[p])
    );
  end

  for (genvar f = 0; f < F; f++) begin : g_fn
    for (genvar p = 0; p < P; p++) begin : g_claim
      assign claim_flat[f*P + p] = (sel_flat[p*SEL_W +: SEL_W] == SEL_W'(f + 1));
    end

    pmx_prio_mux #(.N(P)) u_pm (
      .req   (claim_flat[f*P +: P]),
      .data  (pad_sync),
      .grant (grant_flat[f*P +: P]),
      .any   (hit[f]),
      .y     (win[f])
    );

    assign fn_in[f] = hit[f] ? win[f] : IDLE_MASK[f];
  end
endmodule

// File: rtl/pinmux_chk.sv
module pinmux_chk #(
  parameter int P     = 8,
  parameter int F     = 6,
  parameter int SEL_W = 3,
  parameter int AW    = 4,
  parameter int DW    = 8,
  parameter logic [F-1:0] BUS_MASK  = '0,
  parameter logic [F-1:0] IDLE_MASK = '0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_we,
  input logic [AW-1:0]      cfg_addr,
  input logic [DW-1:0]      cfg_wdata,
  input logic [F-1:0]       fn_oe,
  input logic [F-1:0]       fn_in,
  input logic [P-1:0]       pad_in,
  input logic [P-1:0]       pad_out,
  input logic [P-1:0]       pad_oe,
  input logic [P-1:0]       gpio_in,
  input logic [P*SEL_W-1:0] sel_flat,
  input logic [P-1:0]       gpio_out_q,
  input logic [P-1:0]       gpio_oe_q,
  input logic [F*P-1:0]     claim_flat,
  input logic [F*P-1:0]     grant_flat
);
  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2) |-> (gpio_in == $past(pad_in, 2))); // R8

  for (genvar p = 0; p < P; p++) begin : g_pchk
    logic [SEL_W-1:0] code;
    logic             claims_any;
    assign code = sel_flat[p*SEL_W +: SEL_W];
    always_comb begin
      claims_any = 1'b0;
      for (int f = 0; f < F; f++) claims_any = claims_any | claim_flat[f*P + p];
    end

    AST_GPIO_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      (code == '0) |-> (pad_oe[p] == gpio_oe_q[p] && pad_out[p] == gpio_out_q[p])); // R2

    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(code) > F) |-> (!claims_any && pad_oe[p] == gpio_oe_q[p])); // R9

    AST_CFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 2'd1 && cfg_we && cfg_addr == AW'(p))
        |=> (code == $past(cfg_wdata[SEL_W-1:0]))); // R10

    for (genvar f = 0; f < F; f++) begin : g_bus
      if (BUS_MASK[f]) begin : g_is_bus
        AST_BUS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
          (code == SEL_W'(f + 1)) |-> (pad_oe[p] == fn_oe[f])); // R4
      end
    end
  end

  for (genvar f = 0; f < F; f++) begin : g_fchk
    AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_flat[f*P +: P])); // R5

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (claim_flat[f*P +: P] == '0) |-> (fn_in[f] == IDLE_MASK[f])); // R6
  end
endmodule

bind pinmux_core pinmux_chk #(
  .P(NUM_PINS), .F(NUM_FUNCS), .SEL_W(SEL_W), .AW(AW), .DW(DW),
  .BUS_MASK(BUS_MASK), .IDLE_MASK(IDLE_MASK)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_we     (cfg_we),
  .cfg_addr   (cfg_addr),
  .cfg_wdata  (cfg_wdata),
  .fn_oe      (fn_oe),
  .fn_in      (fn_in),
  .pad_in     (pad_in),
  .pad_out    (pad_out),
  .pad_oe     (pad_oe),
  .gpio_in    (gpio_in),
  .sel_flat   (sel_flat),
  .gpio_out_q (gpio_out_q),
  .gpio_oe_q  (gpio_oe_q),
  .claim_flat (claim_flat),
  .grant_flat (grant_flat)
);

// File: tb/tb_pinmux_core.sv
module tb_pinmux_core;
  localparam int P = 8;
  localparam int F = 6;
  localparam logic [F-1:0] OUTM = 6'b100101;
  localparam logic [F-1:0] BUSM = 6'b011000;
  localparam logic [F-1:0] IDLM = 6'b001100;
  localparam int GOUT_A = P;
  localparam int GOE_A  = P + 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_we = 1'b0;
  logic [3:0]   cfg_addr = '0;
  logic [7:0]   cfg_wdata = '0;
  logic [F-1:0] fn_out = '0;
  logic [F-1:0] fn_oe = '0;
  logic [F-1:0] fn_in;
  logic [P-1:0] pad_in = '0;
  logic [P-1:0] pad_out;
  logic [P-1:0] pad_oe;
  logic [P-1:0] gpio_in;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int           m_sel [P];
  logic [P-1:0] m_gout;
  logic [P-1:0] m_goe;

  always #5 clk = ~clk;

  pinmux_core dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .fn_out(fn_out), .fn_oe(fn_oe), .fn_in(fn_in),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .gpio_in(gpio_in)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a < P) m_sel[a] = int'(d[2:0]);
    else if (a == GOUT_A) m_gout = d;
    else if (a == GOE_A) m_goe = d;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic clear_cfg();
    for (int p = 0; p < P; p++) wr(p, 8'h00);
    wr(GOUT_A, 8'h00);
    wr(GOE_A, 8'h00);
  endtask

  // independent model: pads from code, inputs scanned from top pin down
  task automatic check_all(string req);
    logic [P-1:0] eo, ee;
    logic [F-1:0] ei;
    for (int p = 0; p < P; p++) begin
      int c = m_sel[p];
      if (c >= 1 && c <= F) begin
        eo[p] = fn_out[c-1];
        ee[p] = BUSM[c-1] ? fn_oe[c-1] : OUTM[c-1];
      end else begin
        eo[p] = m_gout[p];
        ee[p] = m_goe[p];
      end
    end
    for (int f = 0; f < F; f++) begin
      ei[f] = IDLM[f];
      for (int p = P-1; p >= 0; p--) if (m_sel[p] == f + 1) ei[f] = pad_in[p];
    end
    chk(req, "pad_out", 32'(pad_out), 32'(eo));
    chk(req, "pad_oe",  32'(pad_oe),  32'(ee));
    chk(req, "fn_in",   32'(fn_in),   32'(ei));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "pad_oe", 32'(pad_oe), 32'h0);
    chk("R1", "pad_out", 32'(pad_out), 32'h0);
    chk("R1", "fn_in", 32'(fn_in), 32'(IDLM));
  endtask

  task automatic t_gpio();
    clear_cfg();
    wr(GOUT_A, 8'hA5);
    wr(GOE_A, 8'h0F);
    chk("R2", "pad_out", 32'(pad_out), 32'hA5);
    chk("R2", "pad_oe", 32'(pad_oe), 32'h0F);
  endtask

  task automatic t_func_out();
    clear_cfg();
    wr(GOE_A, 8'h01);
    wr(2, 8'd1); wr(5, 8'd1);   // two pads on output function 1
    wr(3, 8'd2);                // input function 2
    fn_out = 6'b000001;
    @(negedge clk);
    chk("R3", "pads 2/5 high", 32'(pad_out & 8'h24), 32'h24);
    chk("R3", "oe out/in", 32'(pad_oe), 32'h25);
    check_all("R3");
    fn_out = 6'b000000;
    @(negedge clk);
    chk("R3", "pads 2/5 low", 32'(pad_out & 8'h24), 32'h00);
  endtask

  task automatic t_bus();
    clear_cfg();
    wr(6, 8'd4);                // bus function 4
    fn_oe = 6'b001000; fn_out = 6'b001000;
    @(negedge clk);
    chk("R4", "oe follows fn", 32'(pad_oe[6]), 32'h1);
    chk("R4", "out follows fn", 32'(pad_out[6]), 32'h1);
    fn_oe = 6'b000000;
    @(negedge clk);
    chk("R4", "oe released", 32'(pad_oe[6]), 32'h0);
    check_all("R4");
    fn_out = '0;
  endtask

  task automatic t_prio();
    clear_cfg();
    wr(1, 8'd5); wr(4, 8'd5); wr(7, 8'd5);
    pad_in = 8'b0001_0000;      // pin1=0 pin4=1 pin7=0
    settle();
    chk("R5", "pin1 wins", 32'(fn_in[4]), 32'h0);
    wr(1, 8'd0);
    settle();
    chk("R5", "pin4 wins", 32'(fn_in[4]), 32'h1);
    wr(4, 8'd0);
    settle();
    chk("R5", "pin7 wins", 32'(fn_in[4]), 32'h0);
    pad_in = 8'b1000_0000;
    settle();
    chk("R5", "pin7 follows", 32'(fn_in[4]), 32'h1);
    check_all("R5");
  endtask

  task automatic t_idle();
    clear_cfg();
    pad_in = 8'hFF;
    settle();
    chk("R6", "scl idle", 32'(fn_in[2]), 32'h1);
    chk("R6", "spi idle", 32'(fn_in[5]), 32'h0);
    pad_in = 8'h00;
    settle();
    chk("R6", "all idle", 32'(fn_in), 32'(IDLM));
  endtask

  task automatic t_latency();
    clear_cfg();
    wr(0, 8'd2);
    pad_in = 8'h00;
    settle();
    @(negedge clk);
    pad_in[0] = 1'b1;
    @(negedge clk);
    chk("R8", "one edge", 32'(fn_in[1]), 32'h0);
    chk("R8", "gpio one edge", 32'(gpio_in[0]), 32'h0);
    @(negedge clk);
    chk("R8", "two edges", 32'(fn_in[1]), 32'h1);
    chk("R8", "gpio two edges", 32'(gpio_in[0]), 32'h1);
  endtask

  task automatic t_gpio_in();
    clear_cfg();
    wr(0, 8'd2); wr(3, 8'd4); wr(6, 8'd1);
    pad_in = 8'h5A;
    settle();
    chk("R7", "gpio_in", 32'(gpio_in), 32'h5A);
    pad_in = 8'hC3;
    settle();
    chk("R7", "gpio_in", 32'(gpio_in), 32'hC3);
  endtask

  task automatic t_bad_code();
    clear_cfg();
    wr(0, 8'd2);
    pad_in = 8'h01;
    settle();
    chk("R9", "claimed", 32'(fn_in[1]), 32'h1);
    wr(GOUT_A, 8'h01); wr(GOE_A, 8'h01);
    wr(0, 8'd7);
    settle();
    chk("R9", "no claim", 32'(fn_in[1]), 32'h0);
    chk("R9", "gpio oe", 32'(pad_oe[0]), 32'h1);
    chk("R9", "gpio out", 32'(pad_out[0]), 32'h1);
    check_all("R9");
  endtask

  task automatic t_write();
    clear_cfg();
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'd3; cfg_wdata = 8'd1;
    #2;
    chk("R10", "before edge", 32'(pad_oe[3]), 32'h0);
    @(negedge clk);
    cfg_we = 1'b0;
    m_sel[3] = 1;
    chk("R10", "after edge", 32'(pad_oe[3]), 32'h1);
    wr(12, 8'hFF);
    wr(15, 8'hFF);
    settle();
    check_all("R10");
  endtask

  initial begin
    for (int p = 0; p < P; p++) m_sel[p] = 0;
    m_gout = '0; m_goe = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_gpio();
    t_func_out();
    t_bus();
    t_prio();
    t_idle();
    t_latency();
    t_gpio_in();
    t_bad_code();
    t_write();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule